// File: doc/BRIEF.md
# SPI Register Command Framer

This block is an SPI slave (mode 0, MSB first on the wire) that turns a variable-length byte stream into complete register commands. The first byte after chip-select falls is a register address. The block looks up how many bytes the whole frame holds, collects every data byte, and only then presents the command to internal logic. The command appears as a one-cycle strobe with the address and a right-aligned data word, all in the system clock domain.

Once a frame is complete, the master keeps clocking to read the response. Write-type registers answer with one read-back byte. The block-read query answers with eight bytes from a built-in memory model. An unknown address counts as a one-byte frame and answers with an error byte. The SPI pins are oversampled by the system clock, which must run at least four times faster than the SPI clock. SPI clock rates up to 5 MHz are supported with a 100 MHz system clock.

Top module: `spi_reg_framer`

## Requirements
- R1: After reset, miso_o and cmd_valid_o are 0 and cmd_addr_o and cmd_data_o are all zeros.
- R2: In SPI mode 0, MOSI is captured on the rising edge of sclk_i and MISO changes after the falling edge. Each byte is sent MSB first. The first byte of every frame is the register address.
- R3: Address 0x11 forms a 2-byte frame. cmd_data_o is the single data byte in bits [7:0] with zeros above. The one response byte equals the address, 0x11.
- R4: Address 0x10 forms an 8-byte frame. Its seven data bytes arrive most significant byte first and form a 56-bit word in cmd_data_o[55:0], with bits [63:56] zero. The response byte is 0x10.
- R5: cmd_valid_o stays low until the last data byte of the addressed frame has been received.
- R6: Each complete frame raises cmd_valid_o for exactly one system clock cycle. cmd_addr_o and cmd_data_o are valid in that same cycle.
- R7: Address 0x34 forms a 4-byte frame, and cmd_data_o holds the 24 received data bits. The response is 8 bytes, least significant first. Byte i is the memory byte at address (S+i) mod 65536, where S is data bits [15:0]. The memory byte at address a is a[7:0] XOR a[15:8] XOR 0x3C.
- R8: Any other address forms a 1-byte frame. It strobes cmd_valid_o with cmd_data_o equal to zero and returns one response byte of 0xFF.
- R9: Raising cs_ni in the middle of a frame discards the partial frame without a strobe. The next byte after cs_ni falls again is decoded as an address. miso_o is 0 while cs_ni is high.
- R10: MISO sends 0x00 while command bytes are being received. Bytes clocked in during a response are ignored and produce no command.
- R11: After the last response byte, the next byte in the same chip-select period is decoded as a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SPI clock from master |
| cs_ni | input | 1 | SPI chip-select, active low |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| cmd_valid_o | output | 1 | One-cycle strobe for a complete command |
| cmd_addr_o | output | 8 | Register address of the command |
| cmd_data_o | output | 64 | Right-aligned data word of the command |

## Verification
Completing a frame raises the command strobe and loads the first response byte into the output shifter on the same received-byte event. Every frame test checks both results from that one event. The bench counts strobe cycles on the falling system clock edge, and it samples the response bytes on MISO in the byte slots that follow.

A second pairing is the end of one response and the start of the next frame. This is provoked by keeping chip-select low across two frames. The bench then checks that the byte after the last response byte is taken as a fresh address.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [7:0] REG_FREQ = 8'h10;
  localparam logic [7:0] REG_IFQ  = 8'h11;
  localparam logic [7:0] REG_BLK  = 8'h34;
  localparam int unsigned MAX_RESP = 8;

  typedef enum logic [1:0] {ST_ADDR, ST_DATA, ST_RESP} fr_state_e;

  // total frame bytes including address
  function automatic logic [3:0] frame_bytes(input logic [7:0] a);
    case (a)
      REG_FREQ: frame_bytes = 4'd8;
      REG_IFQ:  frame_bytes = 4'd2;
      REG_BLK:  frame_bytes = 4'd4;
      default:  frame_bytes = 4'd1;
    endcase
  endfunction

  function automatic logic is_known(input logic [7:0] a);
    is_known = (a == REG_FREQ) || (a == REG_IFQ) || (a == REG_BLK);
  endfunction
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_q_o,
  output logic mosi_q_o
);
  logic [STAGES-1:0] sclk_s, cs_s, mosi_s;
  logic sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_s <= {sclk_s[STAGES-2:0], sclk_i};
      cs_s   <= {cs_s[STAGES-2:0], cs_ni};
      mosi_s <= {mosi_s[STAGES-2:0], mosi_i};
      sclk_d <= sclk_s[STAGES-1];
    end
  end

  assign sclk_rise_o = sclk_s[STAGES-1] & ~sclk_d;
  assign sclk_fall_o = ~sclk_s[STAGES-1] & sclk_d;
  assign cs_q_o      = cs_s[STAGES-1];
  assign mosi_q_o    = mosi_s[STAGES-1];
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_q_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         mosi_i,
  input  logic         tx_load_i,
  input  logic [W-1:0] tx_byte_i,
  output logic [W-1:0] rx_byte_o,
  output logic         rx_done_o,
  output logic         miso_o
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] bit_cnt;
  logic [W-1:0]  rx_sr, tx_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      rx_byte_o <= '0;
      rx_done_o <= 1'b0;
    end else if (cs_q_i) begin
      bit_cnt   <= '0;
      tx_sr     <= '0;
      rx_done_o <= 1'b0;
    end else begin
      rx_done_o <= 1'b0;
      if (rise_i) begin
        rx_sr   <= {rx_sr[W-2:0], mosi_i};
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          rx_byte_o <= {rx_sr[W-2:0], mosi_i};
          rx_done_o <= 1'b1;
        end
      end
      // no shift on the fall that closes a byte: next byte already loaded
      if (tx_load_i) tx_sr <= tx_byte_i;
      else if (fall_i && bit_cnt != '0) tx_sr <= {tx_sr[W-2:0], 1'b0};
    end
  end

  assign miso_o = tx_sr[W-1];
endmodule

// File: rtl/spi_cmd_blkrom.sv
module spi_cmd_blkrom #(
  parameter int unsigned AW   = 16,
  parameter int unsigned NB   = 8,
  parameter logic [7:0]  SEED = 8'h3C
) (
  input  logic [AW-1:0]   start_i,
  output logic [NB*8-1:0] word_o
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [AW-1:0] a;
    assign a = start_i + AW'(i);
    assign word_o[i*8 +: 8] = a[7:0] ^ a[AW-1 -: 8] ^ SEED;
  end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_q_i,
  input  logic          rx_done_i,
  input  logic [7:0]    rx_byte_i,
  output logic          tx_load_o,
  output logic [7:0]    tx_byte_o,
  output logic          cmd_valid_o,
  output logic [7:0]    cmd_addr_o,
  output logic [DW-1:0] cmd_data_o
);
  localparam int unsigned NW = $clog2(MAX_RESP + 1);

  fr_state_e   state;
  logic [7:0]  addr_q;
  logic [DW-1:0] acc, full, resp;
  logic [NW-1:0] left;
  logic [MAX_RESP*8-1:0] rom_word;

  assign full = {acc[DW-9:0], rx_byte_i};

  spi_cmd_blkrom #(.AW(16), .NB(MAX_RESP)) u_rom (
    .start_i (full[15:0]),
    .word_o  (rom_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_ADDR;
      addr_q      <= '0;
      acc         <= '0;
      resp        <= '0;
      left        <= '0;
      tx_load_o   <= 1'b0;
      tx_byte_o   <= '0;
      cmd_valid_o <= 1'b0;
      cmd_addr_o  <= '0;
      cmd_data_o  <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      tx_load_o   <= 1'b0;
      if (cs_q_i) begin
        state <= ST_ADDR;
        acc   <= '0;
        left  <= '0;
      end else if (rx_done_i) begin
        tx_load_o <= 1'b1;
        tx_byte_o <= 8'h00;
        unique case (state)
          ST_ADDR: begin
            addr_q <= rx_byte_i;
            acc    <= '0;
            if (frame_bytes(rx_byte_i) == 4'd1) begin
              cmd_valid_o <= 1'b1;
              cmd_addr_o  <= rx_byte_i;
              cmd_data_o  <= '0;
              tx_byte_o   <= is_known(rx_byte_i) ? rx_byte_i : 8'hFF;
              left        <= NW'(1);
              state       <= ST_RESP;
            end else begin
              left  <= NW'(frame_bytes(rx_byte_i) - 4'd1);
              state <= ST_DATA;
            end
          end
          ST_DATA: begin
            acc <= full;
            if (left == NW'(1)) begin
              cmd_valid_o <= 1'b1;
              cmd_addr_o  <= addr_q;
              cmd_data_o  <= full;
              state       <= ST_RESP;
              if (addr_q == REG_BLK) begin
                tx_byte_o <= rom_word[7:0];
                resp      <= DW'(rom_word >> 8);
                left      <= NW'(MAX_RESP);
              end else begin
                tx_byte_o <= addr_q;
                left      <= NW'(1);
              end
            end else begin
              left <= left - 1'b1;
            end
          end
          ST_RESP: begin
            // received byte is a dummy
            if (left == NW'(1)) begin
              state <= ST_ADDR;
            end else begin
              tx_byte_o <= resp[7:0];
              resp      <= resp >> 8;
              left      <= left - 1'b1;
            end
          end
          default: state <= ST_ADDR;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_reg_framer.sv
module spi_reg_framer #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DW          = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          cmd_valid_o,
  output logic [7:0]    cmd_addr_o,
  output logic [DW-1:0] cmd_data_o
);
  logic sclk_rise, sclk_fall, cs_q, mosi_q;
  logic rx_done, tx_load;
  logic [7:0] rx_byte, tx_byte;

  spi_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .sclk_rise_o (sclk_rise),
    .sclk_fall_o (sclk_fall),
    .cs_q_o      (cs_q),
    .mosi_q_o    (mosi_q)
  );

  spi_cmd_shifter #(.W(8)) u_shift (
    .clk_i, .rst_ni,
    .cs_q_i    (cs_q),
    .rise_i    (sclk_rise),
    .fall_i    (sclk_fall),
    .mosi_i    (mosi_q),
    .tx_load_i (tx_load),
    .tx_byte_i (tx_byte),
    .rx_byte_o (rx_byte),
    .rx_done_o (rx_done),
    .miso_o
  );

  spi_cmd_seq #(.DW(DW)) u_seq (
    .clk_i, .rst_ni,
    .cs_q_i      (cs_q),
    .rx_done_i   (rx_done),
    .rx_byte_i   (rx_byte),
    .tx_load_o   (tx_load),
    .tx_byte_o   (tx_byte),
    .cmd_valid_o,
    .cmd_addr_o,
    .cmd_data_o
  );
endmodule

// File: rtl/spi_reg_framer_chk.sv
module spi_reg_framer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_q,
  input logic        miso_o,
  input logic        cmd_valid_o,
  input logic [7:0]  cmd_addr_o,
  input logic [63:0] cmd_data_o
);
  assert_strobe_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  assert_freq_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_addr_o == 8'h10) |-> cmd_data_o[63:56] == 8'h00);

  assert_blk_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_addr_o == 8'h34) |-> cmd_data_o[63:24] == '0);

  assert_ifq_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_addr_o == 8'h11) |-> cmd_data_o[63:8] == '0);

  assert_unknown_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_addr_o != 8'h10 && cmd_addr_o != 8'h11 && cmd_addr_o != 8'h34)
      |-> cmd_data_o == '0);

  assert_idle_miso_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |=> !miso_o);

  assert_no_strobe_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |=> !cmd_valid_o);
endmodule

bind spi_reg_framer spi_reg_framer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_q        (cs_q),
  .miso_o      (miso_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_addr_o  (cmd_addr_o),
  .cmd_data_o  (cmd_data_o)
);

// File: tb/tb_spi_reg_framer.sv
module tb_spi_reg_framer;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;  // sys cycles per sclk half period

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, cmd_valid;
  logic [7:0]  cmd_addr;
  logic [63:0] cmd_data;

  int n_chk = 0, n_fail = 0, n_strobe = 0;
  logic [7:0]  s_addr;
  logic [63:0] s_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_framer dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .cmd_valid_o(cmd_valid), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data)
  );

  always @(negedge clk) if (cmd_valid) begin
    n_strobe++;
    s_addr = cmd_addr;
    s_data = cmd_data;
  end

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(miso == 1'b0 && cmd_valid == 1'b0, "R1 miso/valid", {miso, cmd_valid}, 0);
    chk(cmd_addr == 8'h0 && cmd_data == 64'h0, "R1 addr/data", cmd_data, 0);
  endtask

  task automatic t_ifq();
    logic [7:0] r;
    int base = n_strobe;
    sel();
    xfer(8'h11, r);
    chk(r == 8'h00, "R10 miso during addr", r, 0);
    chk(n_strobe == base, "R5 no early strobe", n_strobe - base, 0);
    xfer(8'hA7, r);
    chk(n_strobe == base + 1, "R6 one strobe cycle", n_strobe - base, 1);
    chk(s_addr == 8'h11 && s_data == 64'hA7, "R3 cmd word", s_data, 64'hA7);
    xfer(8'h00, r);
    chk(r == 8'h11, "R3 ack byte", r, 8'h11);
    desel();
  endtask

  task automatic t_freq();
    logic [7:0] r;
    int base = n_strobe;
    sel();
    xfer(8'h10, r);
    for (int i = 1; i <= 7; i++) begin
      xfer(8'(i), r);
      if (i < 7) chk(n_strobe == base, "R5 partial freq", n_strobe - base, 0);
    end
    chk(n_strobe == base + 1 && s_addr == 8'h10, "R6 freq strobe", s_addr, 8'h10);
    chk(s_data == 64'h0001020304050607, "R4 freq word", s_data, 64'h0001020304050607);
    xfer(8'h00, r);
    chk(r == 8'h10, "R4 ack byte", r, 8'h10);
    desel();
  endtask

  task automatic t_blk(input logic [15:0] st, input logic [7:0] dummy);
    logic [7:0] r;
    int base = n_strobe;
    sel();
    xfer(8'h34, r);
    xfer(8'h00, r);
    xfer(st[15:8], r);
    xfer(st[7:0], r);
    chk(n_strobe == base + 1 && s_data == {48'h0, st}, "R7 blk cmd", s_data, {48'h0, st});
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      e = mem_byte(st + 16'(i));
      xfer(dummy, r);
      chk(r == e, "R7 blk byte", r, e);
    end
    chk(n_strobe == base + 1, "R10 dummy bytes ignored", n_strobe - base, 1);
    desel();
  endtask

  task automatic t_unknown();
    logic [7:0] r;
    int base = n_strobe;
    sel();
    xfer(8'h7E, r);
    chk(n_strobe == base + 1 && s_addr == 8'h7E && s_data == 0, "R8 unknown strobe", s_data, 0);
    xfer(8'h00, r);
    chk(r == 8'hFF, "R8 error byte", r, 8'hFF);
    desel();
  endtask

  task automatic t_abort();
    logic [7:0] r;
    int base = n_strobe;
    sel();
    xfer(8'h10, r);
    xfer(8'h11, r);
    xfer(8'h22, r);
    desel();
    chk(n_strobe == base, "R9 abort no strobe", n_strobe - base, 0);
    chk(miso == 1'b0, "R9 miso idle", miso, 0);
    sel();
    xfer(8'h11, r);
    xfer(8'h3C, r);
    chk(n_strobe == base + 1 && s_addr == 8'h11 && s_data == 64'h3C, "R9 fresh frame", s_data, 64'h3C);
    xfer(8'h00, r);
    chk(r == 8'h11, "R2 ack after abort", r, 8'h11);
    desel();
  endtask

  task automatic t_b2b();
    logic [7:0] r;
    int base = n_strobe;
    sel();
    xfer(8'h11, r);
    xfer(8'h5A, r);
    xfer(8'h00, r);
    chk(r == 8'h11, "R11 first ack", r, 8'h11);
    xfer(8'h7E, r);
    chk(r == 8'h00, "R10 miso after resp", r, 0);
    chk(n_strobe == base + 2 && s_addr == 8'h7E, "R11 second frame", s_addr, 8'h7E);
    xfer(8'h00, r);
    chk(r == 8'hFF, "R11 second resp", r, 8'hFF);
    desel();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_ifq();
    t_freq();
    t_blk(16'h1234, 8'h10);
    t_blk(16'hFFFE, 8'h00);
    t_unknown();
    t_abort();
    t_b2b();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule